// File: doc/BRIEF.md
# Two-Processor Shared Memory Arbiter with Atomic Sequences

This block lets two independent processors share one single-port RAM. Each processor presents its own request, address, write data, write enable and an atomic-hold input. On every clock cycle the arbiter picks at most one processor, connects that processor's address and data to the RAM, and returns a one-cycle ready pulse and read data to it in the following cycle. The other processor is stalled by simply not getting a ready pulse. It keeps presenting the same access until it is served.

Ownership is normally decided anew on every cycle. Ties are broken alternately, so two processors spinning on the same location both make progress. A processor that raises its atomic-hold input on a granted read starts a held sequence. From then on only that processor is served until its read-modify-write completes. A test-and-set built from a held read and a held write-back therefore cannot be split by the other processor. The processor that was held off sees the written-back value on its first access. A behavioural RAM is part of the block.

The grant machine has four states. OPEN_A means no hold is active and a tie goes to A. OPEN_B means no hold is active and a tie goes to B. HELD_A means A owns the RAM. HELD_B means B owns the RAM. The transitions are as follows:
- Serve: an open state grants a processor that has no hold request. The machine moves to the open state that favours the other processor.
- Seize: an open state grants a read with hold asserted. The machine moves to HELD_x for that processor.
- Continue: a held state sees its owner's hold still asserted without a write, or sees the owner idle with hold still high. The machine stays in HELD_x.
- Release: a held state sees its owner's granted write with hold asserted, or any owner cycle with hold low. The machine moves to the open state that favours the other processor.

Top module: `shram_lock_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, both ready outputs and both read-data outputs are 0. After reset no processor owns the RAM, and the first tie goes to processor A.
- R2: In an open state, a lone request is granted in the cycle it is presented. The requesting processor's ready output is high for exactly one cycle, in the next cycle. At most one ready output is high in any cycle.
- R3: In the cycle its ready is high after a granted read, a processor's read-data output equals the RAM word at the presented address. A granted write stores its write data so that any later read of that address returns it.
- R4: In an open state with both processors requesting, the processor that did not receive the most recent grant wins. The loser's access stays pending.
- R5: A granted read with hold asserted starts a held sequence. Until the sequence ends, the other processor receives no ready pulse, even while it requests.
- R6: A held sequence ends on the owner's granted write with hold asserted, or on any owner cycle in which hold is low. After that, a pending access from the other processor is served in the next cycle.
- R7: The hold input of a processor that loses a tie has no effect. The winner is served, and the loser starts a held sequence only when it is itself granted.
- R8: A processor's read-data output changes only in a cycle where its ready is high after a read. Granted writes, and cycles with no grant, leave it unchanged.
- R9: After a held test-and-set that writes 1 over a 0, the other processor's first read of that address returns 1.
- R10: Two spinlock loops built from held test-and-set and a release store of 0 never have their critical sections overlap. No increment of a shared counter is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_a | input | 1 | Processor A access request |
| we_a | input | 1 | Processor A write enable (1 = write) |
| hold_a | input | 1 | Processor A atomic-hold request |
| addr_a | input | ADDR_W | Processor A word address |
| wdata_a | input | DATA_W | Processor A write data |
| rdy_a | output | 1 | Processor A access completed (one-cycle pulse) |
| rdata_a | output | DATA_W | Processor A read data |
| req_b | input | 1 | Processor B access request |
| we_b | input | 1 | Processor B write enable (1 = write) |
| hold_b | input | 1 | Processor B atomic-hold request |
| addr_b | input | ADDR_W | Processor B word address |
| wdata_b | input | DATA_W | Processor B write data |
| rdy_b | output | 1 | Processor B access completed (one-cycle pulse) |
| rdata_b | output | DATA_W | Processor B read data |

## Verification
The embedded properties check the following on every cycle: ready pulses are mutually exclusive, and each one traces back to a request. A tie in an open state goes to the favoured processor. No ready reaches the other processor during a held sequence. A held write closes the sequence. A stalled processor's hold never seizes the RAM. Read data moves only with a ready pulse. The bench's scenarios cover what needs memory contents or history across many cycles: that a held-off processor reads the value a test-and-set left behind, and that two concurrent spinlock loops keep their critical sections disjoint and lose no counter increment. The bench also checks the exact cycle in which the other processor is served after each kind of release.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // number of processors sharing the RAM
    localparam int NM = 2;

    // OPEN_x: cycle-by-cycle arbitration, tie favours x
    // HELD_x: x owns the RAM for an atomic sequence
    typedef enum logic [1:0] {
        ST_OPEN_A = 2'd0,
        ST_OPEN_B = 2'd1,
        ST_HELD_A = 2'd2,
        ST_HELD_B = 2'd3
    } arb_state_e;

endpackage

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
    import arb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [NM-1:0] req,
    input  logic [NM-1:0] we,
    input  logic [NM-1:0] hold,
    output logic [NM-1:0] grant,
    output arb_state_e    state
);

    arb_state_e state_q, state_d;

    // a granted read with hold asserted opens or continues a sequence
    logic [NM-1:0] seize;
    assign seize = hold & ~we;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OPEN_A;
        else     state_q <= state_d;
    end

    // grant and next state
    always_comb begin
        grant   = '0;
        state_d = state_q;
        unique case (state_q)
            ST_OPEN_A: begin
                if (req[0]) begin
                    grant[0] = 1'b1;
                    state_d  = seize[0] ? ST_HELD_A : ST_OPEN_B;
                end else if (req[1]) begin
                    grant[1] = 1'b1;
                    state_d  = seize[1] ? ST_HELD_B : ST_OPEN_A;
                end
            end
            ST_OPEN_B: begin
                if (req[1]) begin
                    grant[1] = 1'b1;
                    state_d  = seize[1] ? ST_HELD_B : ST_OPEN_A;
                end else if (req[0]) begin
                    grant[0] = 1'b1;
                    state_d  = seize[0] ? ST_HELD_A : ST_OPEN_B;
                end
            end
            ST_HELD_A: begin
                if (req[0]) begin
                    grant[0] = 1'b1;
                    state_d  = seize[0] ? ST_HELD_A : ST_OPEN_B;
                end else begin
                    state_d  = hold[0] ? ST_HELD_A : ST_OPEN_B;
                end
            end
            ST_HELD_B: begin
                if (req[1]) begin
                    grant[1] = 1'b1;
                    state_d  = seize[1] ? ST_HELD_B : ST_OPEN_A;
                end else begin
                    state_d  = hold[1] ? ST_HELD_B : ST_OPEN_A;
                end
            end
            default: begin
                grant   = '0;
                state_d = ST_OPEN_A;
            end
        endcase
    end

    assign state = state_q;

    // R6: a held write by the owner closes the sequence
    p_held_write_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HELD_A && req[0] && we[0]) |=> (state_q == ST_OPEN_B));

    p_held_write_closes_b_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HELD_B && req[1] && we[1]) |=> (state_q == ST_OPEN_A));

    // R7: the hold of a processor that loses a tie never seizes the RAM
    p_loser_hold_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPEN_A && req[0] && req[1] && !hold[0]) |=> (state_q != ST_HELD_B));

endmodule

// File: rtl/arb_ram.sv
module arb_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/arb_resp.sv
module arb_resp
    import arb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NM-1:0]             grant,
    input  logic [NM-1:0]             we,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic [NM-1:0]             rdy,
    output logic [NM-1:0][DATA_W-1:0] rdata
);

    // one response register set per processor
    for (genvar m = 0; m < NM; m++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                rdy[m]   <= 1'b0;
                rdata[m] <= '0;
            end else begin
                rdy[m] <= grant[m];
                if (grant[m] && !we[m]) rdata[m] <= mem_rdata;
            end
        end
    end

endmodule

// File: rtl/shram_lock_arbiter.sv
module shram_lock_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_a,
    input  logic              we_a,
    input  logic              hold_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic              rdy_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic              req_b,
    input  logic              we_b,
    input  logic              hold_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic              rdy_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [NM-1:0]             req_v, we_v, hold_v, grant, rdy_v;
    logic [NM-1:0][DATA_W-1:0] rdata_v;
    arb_state_e                state;

    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata, ram_rdata;
    logic              ram_wr;

    assign req_v  = {req_b,  req_a};
    assign we_v   = {we_b,   we_a};
    assign hold_v = {hold_b, hold_a};

    arb_grant_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .req   (req_v),
        .we    (we_v),
        .hold  (hold_v),
        .grant (grant),
        .state (state)
    );

    // winner steers the single RAM port
    always_comb begin
        if (grant[1]) begin
            ram_addr  = addr_b;
            ram_wdata = wdata_b;
        end else begin
            ram_addr  = addr_a;
            ram_wdata = wdata_a;
        end
        ram_wr = |(grant & we_v);
    end

    arb_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .wr    (ram_wr),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    arb_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .we        (we_v),
        .mem_rdata (ram_rdata),
        .rdy       (rdy_v),
        .rdata     (rdata_v)
    );

    assign rdy_a   = rdy_v[0];
    assign rdy_b   = rdy_v[1];
    assign rdata_a = rdata_v[0];
    assign rdata_b = rdata_v[1];

    // R2: never two completions in one cycle
    p_single_ready_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rdy_b, rdy_a}));

    // R2: a completion always follows a request
    p_ready_has_req_r2: assert property (@(posedge clk) disable iff (rst)
        rdy_a |-> $past(req_a));

    // R4: a tie in an open state goes to the favoured processor
    p_tie_to_favoured_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPEN_A && req_a && req_b) |=> (rdy_a && !rdy_b));

    p_tie_to_favoured_b_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPEN_B && req_a && req_b) |=> (rdy_b && !rdy_a));

    // R5: nothing reaches the other processor during a held sequence
    p_held_excludes_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HELD_A) |=> !rdy_b);

    p_held_excludes_b_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HELD_B) |=> !rdy_a);

    // R8: read data moves only together with a ready pulse
    p_rdata_moves_with_rdy_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata_a) |-> rdy_a);

    p_rdata_moves_with_rdy_b_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata_b) |-> rdy_b);

endmodule

// File: tb/sim_shram_lock_arbiter.sv
module sim_shram_lock_arbiter;

    localparam int SEM   = 'h30;
    localparam int CNT   = 'h31;
    localparam int ITERS = 4;
    localparam int INNER = 2;

    typedef struct {
        bit rq;
        bit we;
        bit lk;
        int addr;
        int wd;
    } op_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] d_req = '0, d_we = '0, d_lk = '0;
    logic [5:0] d_addr [2];
    logic [7:0] d_wd   [2];
    logic       rdy_a, rdy_b;
    logic [7:0] rdata_a, rdata_b;

    always #5 clk = ~clk;

    shram_lock_arbiter u0 (
        .clk(clk), .rst(rst),
        .req_a(d_req[0]), .we_a(d_we[0]), .hold_a(d_lk[0]),
        .addr_a(d_addr[0]), .wdata_a(d_wd[0]),
        .rdy_a(rdy_a), .rdata_a(rdata_a),
        .req_b(d_req[1]), .we_b(d_we[1]), .hold_b(d_lk[1]),
        .addr_b(d_addr[1]), .wdata_b(d_wd[1]),
        .rdy_b(rdy_b), .rdata_b(rdata_b)
    );

    int checks = 0, errors = 0, cyc = 0;

    // reference model state
    int       m_st = 0;            // 0 openA, 1 openB, 2 heldA, 3 heldB
    bit [7:0] m_mem [64];
    bit       e_rdy [2];
    bit [7:0] e_rd  [2];
    string    t_rdy [2];
    string    t_rd  [2];

    // processor programs
    op_t qa[$], qb[$];
    bit  pres [2];
    int  mode [2];                 // 0 queue, 1 spinlock
    int  done_cyc [2];
    bit [7:0] rd_log [2];
    int  sp_st [2], sp_it [2], sp_in [2];
    bit [7:0] sp_old [2], sp_val [2];
    bit  in_crit [2];

    task automatic check(bit ok, string tag, int act, int exp, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic model_step();
        int g, ns;
        g = -1;
        for (int m = 0; m < 2; m++) t_rdy[m] = "R2";
        if (d_req[0] && d_req[1]) begin
            for (int m = 0; m < 2; m++) t_rdy[m] = "R4";
        end
        case (m_st)
            0: g = d_req[0] ? 0 : (d_req[1] ? 1 : -1);
            1: g = d_req[1] ? 1 : (d_req[0] ? 0 : -1);
            2: g = d_req[0] ? 0 : -1;
            default: g = d_req[1] ? 1 : -1;
        endcase
        if (m_st < 2 && d_req[0] && d_req[1] && d_lk[1 - g]) begin
            for (int m = 0; m < 2; m++) t_rdy[m] = "R7";
        end
        if (m_st >= 2) begin
            int o;
            o = m_st - 2;
            if (d_req[1 - o]) begin
                for (int m = 0; m < 2; m++) t_rdy[m] = "R5";
            end
            if (d_req[o]) ns = (d_lk[o] && !d_we[o]) ? m_st : (o == 0 ? 1 : 0);
            else          ns = d_lk[o] ? m_st : (o == 0 ? 1 : 0);
            if (ns < 2) begin
                for (int m = 0; m < 2; m++) t_rdy[m] = "R6";
            end
        end else if (g >= 0) begin
            ns = (d_lk[g] && !d_we[g]) ? 2 + g : (g == 0 ? 1 : 0);
        end else begin
            ns = m_st;
        end
        for (int m = 0; m < 2; m++) begin
            e_rdy[m] = (g == m);
            if (g == m && !d_we[m]) begin
                e_rd[m] = m_mem[d_addr[m]];
                t_rd[m] = "R3";
            end else begin
                t_rd[m] = "R8";
            end
        end
        if (g >= 0 && d_we[g]) m_mem[d_addr[g]] = d_wd[g];
        m_st = ns;
    endtask

    task automatic queue_update(int m);
        op_t op;
        if (!pres[m]) return;
        op = (m == 0) ? qa[0] : qb[0];
        if (!op.rq || e_rdy[m]) begin
            if (op.rq) begin
                done_cyc[m] = cyc;
                if (!op.we) rd_log[m] = e_rd[m];
            end
            if (m == 0) void'(qa.pop_front());
            else        void'(qb.pop_front());
        end
    endtask

    task automatic spin_update(int m);
        if (!e_rdy[m]) return;
        case (sp_st[m])
            0: begin sp_old[m] = e_rd[m]; sp_st[m] = 1; end
            1: begin
                if (sp_old[m] == 0) begin
                    in_crit[m] = 1'b1;
                    sp_in[m]   = 0;
                    sp_st[m]   = 2;
                end else begin
                    sp_st[m] = 0;
                end
            end
            2: begin sp_val[m] = e_rd[m]; sp_st[m] = 3; end
            3: begin
                sp_in[m]++;
                sp_st[m] = (sp_in[m] == INNER) ? 4 : 2;
            end
            4: begin
                in_crit[m] = 1'b0;
                sp_it[m]++;
                sp_st[m] = (sp_it[m] == ITERS) ? 5 : 0;
            end
            default: ;
        endcase
    endtask

    task automatic drive(int m);
        op_t op;
        op = '{rq: 0, we: 0, lk: 0, addr: 0, wd: 0};
        pres[m] = 1'b0;
        if (mode[m] == 0) begin
            if (m == 0 && qa.size() > 0) begin op = qa[0]; pres[m] = 1'b1; end
            if (m == 1 && qb.size() > 0) begin op = qb[0]; pres[m] = 1'b1; end
        end else begin
            case (sp_st[m])
                0: op = '{rq: 1, we: 0, lk: 1, addr: SEM, wd: 0};
                1: op = '{rq: 1, we: 1, lk: 1, addr: SEM, wd: int'(sp_old[m] | 8'h01)};
                2: op = '{rq: 1, we: 0, lk: 0, addr: CNT, wd: 0};
                3: op = '{rq: 1, we: 1, lk: 0, addr: CNT, wd: int'(sp_val[m] + 8'd1)};
                4: op = '{rq: 1, we: 1, lk: 0, addr: SEM, wd: 0};
                default: ;
            endcase
        end
        d_req[m]  = op.rq;
        d_we[m]   = op.we;
        d_lk[m]   = op.lk;
        d_addr[m] = 6'(op.addr);
        d_wd[m]   = 8'(op.wd);
    endtask

    // one cycle: compare, advance programs, drive, predict
    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            finish_run();
        end
        check(rdy_a == e_rdy[0], t_rdy[0], rdy_a, e_rdy[0], "rdy_a");
        check(rdy_b == e_rdy[1], t_rdy[1], rdy_b, e_rdy[1], "rdy_b");
        check(rdata_a == e_rd[0], t_rd[0], rdata_a, e_rd[0], "rdata_a");
        check(rdata_b == e_rd[1], t_rd[1], rdata_b, e_rd[1], "rdata_b");
        for (int m = 0; m < 2; m++) begin
            if (mode[m] == 0) queue_update(m);
            else              spin_update(m);
        end
        if (mode[0] == 1 || mode[1] == 1)
            check(!(in_crit[0] && in_crit[1]), "R10", {in_crit[1], in_crit[0]}, 0, "critical overlap");
        for (int m = 0; m < 2; m++) drive(m);
        model_step();
    endtask

    task automatic run_idle();
        while (qa.size() > 0 || qb.size() > 0 ||
               (mode[0] == 1 && sp_st[0] != 5) || (mode[1] == 1 && sp_st[1] != 5))
            step();
        step();
        step();
    endtask

    function automatic op_t rd(int a, bit lk);
        return '{rq: 1, we: 0, lk: lk, addr: a, wd: 0};
    endfunction

    function automatic op_t wr(int a, int v, bit lk);
        return '{rq: 1, we: 1, lk: lk, addr: a, wd: v};
    endfunction

    function automatic op_t nop();
        return '{rq: 0, we: 0, lk: 0, addr: 0, wd: 0};
    endfunction

    initial begin
        int a_wr_done;
        for (int m = 0; m < 2; m++) begin
            d_addr[m] = '0; d_wd[m] = '0;
            e_rdy[m] = 0; e_rd[m] = 0; t_rdy[m] = "R1"; t_rd[m] = "R1";
            mode[m] = 0; pres[m] = 0; in_crit[m] = 0;
            sp_st[m] = 0; sp_it[m] = 0; sp_in[m] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs idle in reset
        check(rdy_a == 0,   "R1", rdy_a,   0, "rdy_a in reset");
        check(rdy_b == 0,   "R1", rdy_b,   0, "rdy_b in reset");
        check(rdata_a == 0, "R1", rdata_a, 0, "rdata_a in reset");
        check(rdata_b == 0, "R1", rdata_b, 0, "rdata_b in reset");
        rst = 1'b0;

        // R1/R4: first tie goes to A; R2/R3 plain writes and reads
        qa.push_back(wr('h05, 'h11, 0));
        qb.push_back(wr('h06, 'h22, 0));
        qa.push_back(rd('h06, 0));
        qb.push_back(rd('h05, 0));
        run_idle();
        check(done_cyc[0] < done_cyc[1], "R1", done_cyc[0], done_cyc[1], "first tie winner A");
        check(rd_log[0] == 8'h22, "R3", rd_log[0], 'h22, "A reads B's word");
        check(rd_log[1] == 8'h11, "R3", rd_log[1], 'h11, "B reads A's word");

        // R4: sustained tie alternates
        for (int i = 0; i < 4; i++) begin
            qa.push_back(rd('h05, 0));
            qb.push_back(rd('h06, 0));
        end
        run_idle();

        // R8: write leaves read data unchanged
        qa.push_back(rd('h06, 0));
        qa.push_back(wr('h07, 'h5a, 0));
        run_idle();
        check(rdata_a == 8'h22, "R8", rdata_a, 'h22, "rdata_a after write");

        // R5/R9: held test-and-set by A, B reads in between
        qa.push_back(wr('h10, 'h00, 0));
        run_idle();
        qa.push_back(rd('h10, 1));
        qa.push_back(wr('h10, 'h01, 1));
        qb.push_back(nop());
        qb.push_back(rd('h10, 0));
        run_idle();
        a_wr_done = done_cyc[0];
        check(rd_log[1] == 8'h01, "R9", rd_log[1], 1, "B sees test-and-set result");
        check(done_cyc[1] == a_wr_done + 1, "R5", done_cyc[1], a_wr_done + 1, "B served after held write");

        // R6: sequence ended by an owner cycle with hold low
        qa.push_back(rd('h05, 1));
        qa.push_back(rd('h06, 0));
        qb.push_back(nop());
        qb.push_back(rd('h07, 0));
        run_idle();
        check(done_cyc[1] == done_cyc[0] + 1, "R6", done_cyc[1], done_cyc[0] + 1, "B served after hold drop");
        check(rd_log[1] == 8'h5a, "R3", rd_log[1], 'h5a, "B reads 0x07");

        // R7: loser's hold ignored; the loser seizes later on its own grant
        qa.push_back(rd('h05, 0));
        qb.push_back(rd('h06, 1));
        qb.push_back(wr('h06, 'h23, 1));
        run_idle();
        check(done_cyc[0] < done_cyc[1], "R7", done_cyc[0], done_cyc[1], "winner served before held loser");

        // R10: two spinlock loops at once
        qa.push_back(wr(SEM, 0, 0));
        qb.push_back(wr(CNT, 0, 0));
        run_idle();
        mode[0] = 1; mode[1] = 1;
        run_idle();
        mode[0] = 0; mode[1] = 0;
        qa.push_back(rd(CNT, 0));
        qb.push_back(rd(SEM, 0));
        run_idle();
        check(rd_log[0] == 8'(2 * ITERS * INNER), "R10", rd_log[0], 2 * ITERS * INNER, "shared counter");
        check(rd_log[1] == 8'h00, "R10", rd_log[1], 0, "semaphore released");

        finish_run();
    end

endmodule